// File: doc/BRIEF.md
# Multi-level GPU page table walker

This block turns a 49-bit GPU virtual address into a physical address. It walks a five-level tree held in memory: four directory levels and then a page-table level. A walk starts from a root table base address. The block issues one 32-bit entry read at a time on a plain request/response memory port. It decodes each returned entry and either descends to the next table, finishes with a physical address, or finishes with a fault.

The levels do not all have the same index width or entry size. The root level takes a 2-bit index. The next two directory levels and the final page-table level each take a 9-bit index. The last directory level takes an 8-bit index and holds 16-byte entries, and only the upper 8 bytes of each of those entries are read. Only one walk is in flight at a time. Completion is signalled by a single-cycle `done` pulse, with `fault` and `paddr` valid alongside it.

Top module: `gpu_ptw`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are all low.
- R2: The first read of a walk goes to `root_base + vaddr[48:47]*8`.
- R3: The deeper levels are indexed, in order, by `vaddr[46:38]`, `vaddr[37:29]`, `vaddr[28:21]` and `vaddr[20:12]`. The entry stride is 8 bytes, except at the level indexed by `vaddr[28:21]`: its stride is 16 bytes and it is read at byte offset +8.
- R4: A returned entry is decoded as follows: bit 0 is the leaf flag, bits 2:1 are the target, and bits 31:8 are the address field. Any nonzero target is valid. For a valid non-leaf entry, the next table base is the address field shifted left by 12.
- R5: An entry whose target is 0 ends the walk at once with `fault`=1, and no further reads are issued.
- R6: A valid entry with the leaf flag set, at any level, ends the walk with `fault`=0 and `paddr = {address field, vaddr[11:0]}`.
- R7: A valid non-leaf entry returned at the fifth (last) level ends the walk with `fault`=1.
- R8: Each request is a single-cycle `mem_req_valid` pulse, and the next request waits for the response to the previous one. A `start` seen while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle per walk, and `fault` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| root_base | input | 36 | Byte address of the root table |
| vaddr | input | 49 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (with `done`) |
| paddr | output | 36 | Translated physical address (with `done`) |

## Verification
Suppose `start` is sampled at clock edge 0. The request is then visible after that edge. A response sampled at edge k sends the next request, or raises `done`, right after edge k. With a memory that answers L cycles after the cycle of the request, a walk of N reads raises `done` N*(2+L) edges after the start edge. The bench samples every output on the falling edge. It counts falling edges from the start pulse, and it requires `done` to show up on exactly the predicted falling edge and to be gone on the next one. The read count, the first request address, and `fault`/`paddr` are all checked on the falling edge where `done` is high.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   localparam int NLVL     = 5;
   localparam int PG_SHIFT = 12;
   localparam int VA_MIN   = 49;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } walk_state_e;

   // least significant virtual-address bit of each level's index
   function automatic int idx_lsb(input int l);
      case (l)
         0:       return 47;
         1:       return 38;
         2:       return 29;
         3:       return 21;
         default: return 12;
      endcase
   endfunction

   function automatic int idx_bits(input int l);
      case (l)
         0:       return 2;
         3:       return 8;
         default: return 9;
      endcase
   endfunction

   // log2 of the entry stride in bytes
   function automatic int ent_shift(input int l);
      return (l == 3) ? 4 : 3;
   endfunction

   // byte offset of the meaningful word inside an entry
   function automatic int ent_off(input int l);
      return (l == 3) ? 8 : 0;
   endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
   import ptw_pkg::*;
#(
   parameter int VA_W  = 49,
   parameter int PA_W  = 36,
   parameter int LVL_W = 3
) (
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [VA_W-1:0]  va,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  ent_addr
);

   if (VA_W < VA_MIN) begin : g_bad_va
      $error("ptw_entry_addr: VA_W too narrow for the level layout");
   end
   if ((1 << LVL_W) < NLVL) begin : g_bad_lvl
      $error("ptw_entry_addr: LVL_W cannot count all levels");
   end

   logic [PA_W-1:0] cand [NLVL];
   logic            unused_va;

   assign unused_va = ^va;

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      localparam int LSB  = idx_lsb(g);
      localparam int BITS = idx_bits(g);
      localparam int SH   = ent_shift(g);
      localparam int OFF  = ent_off(g);
      logic [BITS-1:0] idx;
      assign idx     = va[LSB+BITS-1:LSB];
      assign cand[g] = tbl_base + (PA_W'(idx) << SH) + PA_W'(OFF);
   end

   always_comb begin
      ent_addr = '0;
      for (int i = 0; i < NLVL; i++) begin
         if (lvl == LVL_W'(i)) ent_addr = cand[i];
      end
   end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
   parameter int ENTRY_W  = 32,
   parameter int AFIELD_W = 24
) (
   input  logic [ENTRY_W-1:0]  raw,
   output logic                ent_valid,
   output logic                ent_leaf,
   output logic [AFIELD_W-1:0] ent_addr
);

   localparam int LOW_W = ENTRY_W - AFIELD_W;

   if (LOW_W < 3) begin : g_bad_layout
      $error("ptw_entry_decode: address field overlaps flag bits");
   end

   logic unused_flags;

   assign unused_flags = ^raw[LOW_W-1:3];
   assign ent_leaf     = raw[0];
   assign ent_valid    = |raw[2:1];
   assign ent_addr     = raw[ENTRY_W-1 -: AFIELD_W];

endmodule

// File: rtl/gpu_ptw.sv
module gpu_ptw
   import ptw_pkg::*;
#(
   parameter int VA_W     = 49,
   parameter int ENTRY_W  = 32,
   parameter int AFIELD_W = 24,
   parameter int PA_W     = AFIELD_W + PG_SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PA_W-1:0]     root_base,
   input  logic [VA_W-1:0]     vaddr,
   output logic                busy,
   output logic                mem_req_valid,
   output logic [PA_W-1:0]     mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [ENTRY_W-1:0]  mem_rsp_data,
   output logic                done,
   output logic                fault,
   output logic [PA_W-1:0]     paddr
);

   localparam int LVL_W = $clog2(NLVL);

   if (PA_W != AFIELD_W + PG_SHIFT) begin : g_bad_pa
      $error("gpu_ptw: PA_W must equal AFIELD_W plus the page shift");
   end

   walk_state_e         st_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [PA_W-1:0]     base_q;
   logic [VA_W-1:0]     va_q;
   logic                done_q, fault_q;
   logic [PA_W-1:0]     paddr_q;
   logic                dec_valid, dec_leaf;
   logic [AFIELD_W-1:0] dec_addr;
   logic                at_last;

   ptw_entry_addr #(
      .VA_W (VA_W),
      .PA_W (PA_W),
      .LVL_W(LVL_W)
   ) u_addr (
      .tbl_base(base_q),
      .va      (va_q),
      .lvl     (lvl_q),
      .ent_addr(mem_req_addr)
   );

   ptw_entry_decode #(
      .ENTRY_W (ENTRY_W),
      .AFIELD_W(AFIELD_W)
   ) u_dec (
      .raw      (mem_rsp_data),
      .ent_valid(dec_valid),
      .ent_leaf (dec_leaf),
      .ent_addr (dec_addr)
   );

   assign at_last       = (lvl_q == LVL_W'(NLVL - 1));
   assign busy          = (st_q != ST_IDLE);
   assign mem_req_valid = (st_q == ST_REQ);
   assign done          = done_q;
   assign fault         = fault_q;
   assign paddr         = paddr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         lvl_q   <= '0;
         base_q  <= '0;
         va_q    <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         paddr_q <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  va_q   <= vaddr;
                  base_q <= root_base;
                  lvl_q  <= '0;
                  st_q   <= ST_REQ;
               end
            end
            ST_REQ: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!dec_valid || (!dec_leaf && at_last)) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     paddr_q <= '0;
                     st_q    <= ST_IDLE;
                  end else if (dec_leaf) begin
                     done_q  <= 1'b1;
                     paddr_q <= {dec_addr, va_q[PG_SHIFT-1:0]};
                     st_q    <= ST_IDLE;
                  end else begin
                     base_q <= {dec_addr, {PG_SHIFT{1'b0}}};
                     lvl_q  <= lvl_q + 1'b1;
                     st_q   <= ST_REQ;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R8: requests are single-cycle pulses
   a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R8: a walk only begins on a start request
   a_r8_start_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R9: completion is a one-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: fault is only reported alongside done
   a_r9_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   // R7: the walk never descends past the last level
   a_r7_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (lvl_q < LVL_W'(NLVL)));

endmodule

// File: tb/tb_gpu_ptw.sv
module tb_gpu_ptw;

   localparam logic [35:0] ROOT = 36'h000_001_000;

   typedef struct packed {
      logic [48:0] va;
      logic        flt;
      logic [35:0] pa;
      logic [3:0]  nrd;
   } vec_t;

   // vaddr, expected fault, expected paddr, expected read count
   localparam vec_t VECS [6] = '{
      '{49'h1_2345_6789_ABCD, 1'b0, 36'h0ABCDEBCD, 4'd5},
      '{49'h1_2345_6789_BBCD, 1'b0, 36'h000123BCD, 4'd5},
      '{49'h0_4000_0000_5555, 1'b0, 36'h777777555, 4'd3},
      '{49'h1_8000_0000_0000, 1'b1, 36'h0,         4'd1},
      '{49'h1_2345_6789_8BCD, 1'b1, 36'h0,         4'd5},
      '{49'h0_0000_0000_1000, 1'b1, 36'h0,         4'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [35:0] root_base = ROOT;
   logic [48:0] vaddr = '0;
   logic        busy, mem_req_valid, done, fault;
   logic [35:0] mem_req_addr, paddr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [logic [35:0]];
   logic [35:0] next_tbl = 36'h000_010_000;
   int          mem_lat = 0;
   int          nreads = 0;
   logic [35:0] first_addr = '0;
   logic        pend = 1'b0;
   logic [35:0] pend_addr = '0;
   int          cnt = 0;

   always #5 clk = ~clk;

   gpu_ptw dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .root_base    (root_base),
      .vaddr        (vaddr),
      .busy         (busy),
      .mem_req_valid(mem_req_valid),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .done         (done),
      .fault        (fault),
      .paddr        (paddr)
   );

   // memory model: answers mem_lat cycles after the request cycle
   always @(negedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            pend          <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
      if (mem_req_valid) begin
         if (nreads == 0) first_addr = mem_req_addr;
         nreads    = nreads + 1;
         pend      <= 1'b1;
         pend_addr <= mem_req_addr;
         cnt       <= mem_lat;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] ent(input logic [35:0] b, input logic [48:0] va,
                                       input int l);
      case (l)
         0:       return b + {va[48:47], 3'b0};
         1:       return b + {va[46:38], 3'b0};
         2:       return b + {va[37:29], 3'b0};
         3:       return b + {va[28:21], 4'b0} + 36'd8;
         default: return b + {va[20:12], 3'b0};
      endcase
   endfunction

   task automatic map_va(input logic [48:0] va, input logic [23:0] ppn,
                         input int leaf_lvl, input bit leaf_flag);
      logic [35:0] b = ROOT;
      for (int l = 0; l <= leaf_lvl; l++) begin
         logic [35:0] a = ent(b, va, l);
         if (l == leaf_lvl) begin
            mem[a] = {ppn, 5'b0, (leaf_lvl == 4) ? 2'b01 : 2'b11, leaf_flag};
         end else if (mem.exists(a)) begin
            b = {mem[a][31:8], 12'h000};
         end else begin
            mem[a] = {next_tbl[35:12], 5'b0, 2'b10, 1'b0};
            // decoy leaf in the unused lower half of a 16-byte entry
            if (l == 3) mem[a - 36'd8] = {24'hFFFFFF, 5'b0, 2'b01, 1'b1};
            b = next_tbl;
            next_tbl = next_tbl + 36'h1000;
         end
      end
   endtask

   task automatic walk(input logic [48:0] va, input int lat, output bit f,
                       output logic [35:0] pa, output int cyc, output int rd,
                       output bit pulse_ok);
      mem_lat = lat;
      nreads  = 0;
      @(negedge clk);
      start = 1'b1;
      vaddr = va;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      f  = fault;
      pa = paddr;
      rd = nreads;
      @(negedge clk);
      pulse_ok = !done;
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit          f, pok;
      logic [35:0] pa;
      int          cyc, rd;

      map_va(VECS[0].va, 24'h0ABCDE, 4, 1'b1);
      map_va(VECS[1].va, 24'h000123, 4, 1'b1);
      map_va(VECS[2].va, 24'h777777, 2, 1'b1);
      map_va(VECS[5].va, 24'h000555, 4, 1'b0);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !fault && !mem_req_valid, "R1 reset outputs",
          {busy, done, fault, mem_req_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req_valid, "R1 idle after reset",
          {busy, done, mem_req_valid}, 0);

      for (int i = 0; i < 6; i++) begin
         walk(VECS[i].va, 0, f, pa, cyc, rd, pok);
         // R5 R7: fault cases, R6: leaf result
         chk(f == VECS[i].flt, $sformatf("R5 R7 fault flag vec%0d", i), f, VECS[i].flt);
         if (!VECS[i].flt)
            chk(pa == VECS[i].pa, $sformatf("R6 R3 paddr vec%0d", i), pa, VECS[i].pa);
         // R5: no reads after an invalid entry; R3 R4: descent count
         chk(rd == VECS[i].nrd, $sformatf("R4 R5 read count vec%0d", i), rd, VECS[i].nrd);
         // R8: one read per two cycles with a zero-latency memory
         chk(cyc == 2 * VECS[i].nrd + 1, $sformatf("R8 done timing vec%0d", i), cyc,
             2 * VECS[i].nrd + 1);
         // R9: done lasts one cycle
         chk(pok, $sformatf("R9 done pulse vec%0d", i), !pok, 0);
         if (i == 0)
            chk(first_addr == ROOT + 36'd16, "R2 root entry address", first_addr,
                ROOT + 36'd16);
         if (i == 3)
            chk(first_addr == ROOT + 36'd24, "R2 highest root index", first_addr,
                ROOT + 36'd24);
      end

      // R8: slow memory, requests wait for responses
      walk(VECS[0].va, 3, f, pa, cyc, rd, pok);
      chk(cyc == 5 * 5 + 1, "R8 slow memory timing", cyc, 26);
      chk(!f && pa == VECS[0].pa, "R6 slow memory paddr", pa, VECS[0].pa);
      chk(rd == 5, "R8 slow memory reads", rd, 5);

      // R8: start while busy is ignored
      mem_lat = 0;
      nreads  = 0;
      @(negedge clk);
      start = 1'b1;
      vaddr = VECS[1].va;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1;
      vaddr = VECS[2].va;
      @(negedge clk);
      start = 1'b0;
      cyc = 3;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      chk(!fault && paddr == VECS[1].pa, "R8 start ignored while busy", paddr, VECS[1].pa);
      chk(cyc == 11, "R8 ignored start timing", cyc, 11);
      @(negedge clk);
      chk(!done && !busy, "R9 single done after ignored start", {done, busy}, 0);
      repeat (3) @(negedge clk);
      chk(nreads == 5 && !busy, "R8 no second walk launched", nreads, 5);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule